// File: doc/BRIEF.md
# Register Transfer, Test and Subtract Execution Unit

This block is the single-cycle execute stage for a small 8-bit processor core. It holds the architectural registers: an accumulator, a 16-bit index register kept as a high byte and a low byte, a 16-bit stack pointer, and an 8-bit condition code byte. The condition code byte carries overflow, half-carry, interrupt mask, negative, zero and carry flags. Each cycle it may receive one already-fetched single-byte opcode, plus the memory operand when the instruction needs one. On the next clock edge it commits the new register and flag values.

The unit handles four groups of work. It moves values between registers, and between the stack pointer and the index register. It copies the accumulator to and from the condition codes. It tests the accumulator, the index low byte or a memory operand for negative or zero. It subtracts a memory operand from the accumulator. Each group changes only its own fixed set of flags. Address generation, operand fetch and interrupt entry belong to the neighbouring pipeline stages. An opcode the unit does not know leaves all state alone and raises a one-cycle illegal-opcode indication.

Top module: `xfer_exec_unit`

## Requirements
- R1: While `rst` is high, and after the first clock edge with it high, the state reads: `acc`=0x00, `idx_h`=0x00, `idx_x`=0x00, `stk`=0x00FF, `ccr`=0x68 (only the mask flag set) and `illegal`=0.
- R2: `ccr` bit order is overflow=7, bit 6 and bit 5 always 1, half-carry=4, mask=3, negative=2, zero=1, carry=0. Opcode 0x97 copies `acc` into `idx_x`, and 0x9F copies `idx_x` into `acc`. Neither changes `ccr`.
- R3: Opcode 0x95 loads {`idx_h`,`idx_x`} with `stk`+1, and 0x94 loads `stk` with {`idx_h`,`idx_x`}−1. Both wrap modulo 2^16 and leave `ccr` unchanged.
- R4: Opcode 0x84 copies `acc` into the condition codes. Opcode 0x85 copies the full `ccr` byte into `acc`.
- R5: The test opcodes are 0x4D (accumulator), 0x5D (index low byte), and 0x3D, 0x6D, 0x7D (memory operand). Each clears overflow and sets negative to bit 7 of the tested value. It sets zero when the value is 0x00. It leaves half-carry, mask, carry and every data register unchanged.
- R6: Subtract sets `acc` to `acc`−operand modulo 256. Carry is set on an unsigned borrow. Overflow is set when the operands differ in sign and the result sign differs from the old `acc` sign. Negative and zero follow the result. Half-carry and mask are unchanged.
- R7: Subtract is recognised on each of the opcodes 0xA0, 0xB0, 0xC0, 0xD0, 0xE0 and 0xF0, and each takes its operand from `mem_operand`.
- R8: A valid opcode outside the sets named in R2 to R7 changes no register and no flag, and drives `illegal` high for exactly the following cycle.
- R9: A cycle with `op_valid` low changes no state and leaves `illegal` low, whatever `opcode` holds.
- R10: Bits 6 and 5 of `ccr` read as 1 at all times, including right after 0x84 copies a value whose bits 6 and 5 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An opcode is presented this cycle |
| opcode | input | 8 | Decoded single-byte opcode |
| mem_operand | input | 8 | Memory operand for test and subtract forms |
| acc | output | 8 | Accumulator |
| idx_h | output | 8 | Index register high byte |
| idx_x | output | 8 | Index register low byte |
| stk | output | 16 | Stack pointer |
| ccr | output | 8 | Condition code byte |
| illegal | output | 1 | Previous cycle held an unknown valid opcode |

## Verification
The bench aims at the asymmetric stack-pointer offsets, including the wrap at 0xFFFF to 0x0000. A design that reused the same offset in both directions, or dropped the carry into the high byte, would end with wrong index or stack values. It drives subtracts that borrow, that overflow with and without a borrow, and that give exactly zero. A design that took overflow from the carry or updated half-carry would show a wrong `ccr`. It copies 0x00 into the condition codes to prove bits 6 and 5 stay set. It also checks that tests of a memory operand never touch the accumulator, and that unknown or idle opcodes freeze every register.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

    localparam int DW = 8;
    localparam int AW = 16;

    // Condition code bit positions inside the visible byte
    localparam int CC_V = 7;
    localparam int CC_H = 4;
    localparam int CC_I = 3;
    localparam int CC_N = 2;
    localparam int CC_Z = 1;
    localparam int CC_C = 0;

    localparam logic [DW-1:0] OPC_TAP  = 8'h84;
    localparam logic [DW-1:0] OPC_TPA  = 8'h85;
    localparam logic [DW-1:0] OPC_TAX  = 8'h97;
    localparam logic [DW-1:0] OPC_TXA  = 8'h9F;
    localparam logic [DW-1:0] OPC_TSX  = 8'h95;
    localparam logic [DW-1:0] OPC_TXS  = 8'h94;
    localparam logic [DW-1:0] OPC_TSTA = 8'h4D;
    localparam logic [DW-1:0] OPC_TSTX = 8'h5D;

    localparam int N_SUB_OPS = 6;
    localparam logic [N_SUB_OPS-1:0][DW-1:0] SUB_OPCODES =
        {8'hF0, 8'hE0, 8'hD0, 8'hC0, 8'hB0, 8'hA0};

    localparam int N_TSTM_OPS = 3;
    localparam logic [N_TSTM_OPS-1:0][DW-1:0] TSTM_OPCODES =
        {8'h7D, 8'h6D, 8'h3D};

    typedef enum logic [3:0] {
        K_IDLE,
        K_CC_FROM_A,
        K_A_FROM_CC,
        K_X_FROM_A,
        K_A_FROM_X,
        K_HX_FROM_SP,
        K_SP_FROM_HX,
        K_TEST_A,
        K_TEST_X,
        K_TEST_M,
        K_SUB_M,
        K_UNKNOWN
    } op_kind_e;

    typedef struct packed {
        logic v;
        logic h;
        logic i;
        logic n;
        logic z;
        logic c;
    } flags_t;

    typedef struct packed {
        logic [DW-1:0] a;
        logic [DW-1:0] h;
        logic [DW-1:0] x;
        logic [AW-1:0] sp;
        flags_t        f;
    } arch_state_t;

    typedef struct packed {
        logic [DW-1:0] diff;
        logic          borrow;
        logic          ovf;
    } sub_out_t;

    function automatic logic [DW-1:0] flags_to_byte(flags_t f);
        logic [DW-1:0] b;
        b       = '0;
        b[6]    = 1'b1;
        b[5]    = 1'b1;
        b[CC_V] = f.v;
        b[CC_H] = f.h;
        b[CC_I] = f.i;
        b[CC_N] = f.n;
        b[CC_Z] = f.z;
        b[CC_C] = f.c;
        return b;
    endfunction

    function automatic flags_t byte_to_flags(logic [DW-1:0] b);
        flags_t f;
        f.v = b[CC_V];
        f.h = b[CC_H];
        f.i = b[CC_I];
        f.n = b[CC_N];
        f.z = b[CC_Z];
        f.c = b[CC_C];
        return f;
    endfunction

    function automatic sub_out_t sub_bytes(logic [DW-1:0] lhs, logic [DW-1:0] rhs);
        sub_out_t      o;
        logic [DW:0]   wide;
        wide     = {1'b0, lhs} - {1'b0, rhs};
        o.diff   = wide[DW-1:0];
        o.borrow = wide[DW];
        o.ovf    = (lhs[DW-1] ^ rhs[DW-1]) & (lhs[DW-1] ^ wide[DW-1]);
        return o;
    endfunction

    function automatic flags_t test_flags(flags_t cur, logic [DW-1:0] val);
        flags_t f;
        f   = cur;
        f.v = 1'b0;
        f.n = val[DW-1];
        f.z = (val == '0);
        return f;
    endfunction

endpackage

// File: rtl/xfer_decode.sv
module xfer_decode
    import xfer_pkg::*;
(
    input  logic          op_valid,
    input  logic [DW-1:0] opcode,
    output op_kind_e      kind
);

    logic [N_SUB_OPS-1:0]  sub_hit;
    logic [N_TSTM_OPS-1:0] tstm_hit;

    for (genvar g = 0; g < N_SUB_OPS; g++) begin : g_sub
        assign sub_hit[g] = (opcode == SUB_OPCODES[g]);
    end

    for (genvar g = 0; g < N_TSTM_OPS; g++) begin : g_tstm
        assign tstm_hit[g] = (opcode == TSTM_OPCODES[g]);
    end

    always_comb begin
        if (!op_valid) begin
            kind = K_IDLE;
        end else if (|sub_hit) begin
            kind = K_SUB_M;
        end else if (|tstm_hit) begin
            kind = K_TEST_M;
        end else begin
            unique case (opcode)
                OPC_TAP:  kind = K_CC_FROM_A;
                OPC_TPA:  kind = K_A_FROM_CC;
                OPC_TAX:  kind = K_X_FROM_A;
                OPC_TXA:  kind = K_A_FROM_X;
                OPC_TSX:  kind = K_HX_FROM_SP;
                OPC_TXS:  kind = K_SP_FROM_HX;
                OPC_TSTA: kind = K_TEST_A;
                OPC_TSTX: kind = K_TEST_X;
                default:  kind = K_UNKNOWN;
            endcase
        end
    end

endmodule

// File: rtl/xfer_alu.sv
module xfer_alu
    import xfer_pkg::*;
(
    input  op_kind_e      kind,
    input  logic [DW-1:0] operand,
    input  arch_state_t   cur,
    output arch_state_t   nxt,
    output logic          bad
);

    sub_out_t      sub_r;
    logic [AW-1:0] hx_cur;
    logic [AW-1:0] hx_inc_sp;

    assign sub_r     = sub_bytes(cur.a, operand);
    assign hx_cur    = {cur.h, cur.x};
    assign hx_inc_sp = cur.sp + 1'b1;

    always_comb begin
        nxt = cur;
        bad = 1'b0;
        unique case (kind)
            K_CC_FROM_A:  nxt.f = byte_to_flags(cur.a);
            K_A_FROM_CC:  nxt.a = flags_to_byte(cur.f);
            K_X_FROM_A:   nxt.x = cur.a;
            K_A_FROM_X:   nxt.a = cur.x;
            K_HX_FROM_SP: {nxt.h, nxt.x} = hx_inc_sp;
            K_SP_FROM_HX: nxt.sp = hx_cur - 1'b1;
            K_TEST_A:     nxt.f = test_flags(cur.f, cur.a);
            K_TEST_X:     nxt.f = test_flags(cur.f, cur.x);
            K_TEST_M:     nxt.f = test_flags(cur.f, operand);
            K_SUB_M: begin
                nxt.a   = sub_r.diff;
                nxt.f   = test_flags(cur.f, sub_r.diff);
                nxt.f.v = sub_r.ovf;
                nxt.f.c = sub_r.borrow;
            end
            K_UNKNOWN:    bad = 1'b1;
            default:      nxt = cur;
        endcase
    end

endmodule

// File: rtl/xfer_regs.sv
module xfer_regs
    import xfer_pkg::*;
#(
    parameter logic [AW-1:0] SP_INIT = 16'h00FF
) (
    input  logic        clk,
    input  logic        rst,
    input  arch_state_t nxt,
    input  logic        bad,
    output arch_state_t cur,
    output logic        illegal_q
);

    arch_state_t reset_val;

    always_comb begin
        reset_val     = '0;
        reset_val.sp  = SP_INIT;
        reset_val.f.i = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur       <= reset_val;
            illegal_q <= 1'b0;
        end else begin
            cur       <= nxt;
            illegal_q <= bad;
        end
    end

endmodule

// File: rtl/xfer_exec_unit.sv
module xfer_exec_unit
    import xfer_pkg::*;
#(
    parameter logic [AW-1:0] SP_INIT = 16'h00FF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          op_valid,
    input  logic [DW-1:0] opcode,
    input  logic [DW-1:0] mem_operand,
    output logic [DW-1:0] acc,
    output logic [DW-1:0] idx_h,
    output logic [DW-1:0] idx_x,
    output logic [AW-1:0] stk,
    output logic [DW-1:0] ccr,
    output logic          illegal
);

    op_kind_e    kind;
    arch_state_t st_cur;
    arch_state_t st_nxt;
    logic        bad;

    xfer_decode u_dec (
        .op_valid (op_valid),
        .opcode   (opcode),
        .kind     (kind)
    );

    xfer_alu u_alu (
        .kind    (kind),
        .operand (mem_operand),
        .cur     (st_cur),
        .nxt     (st_nxt),
        .bad     (bad)
    );

    xfer_regs #(.SP_INIT(SP_INIT)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .nxt       (st_nxt),
        .bad       (bad),
        .cur       (st_cur),
        .illegal_q (illegal)
    );

    assign acc   = st_cur.a;
    assign idx_h = st_cur.h;
    assign idx_x = st_cur.x;
    assign stk   = st_cur.sp;
    assign ccr   = flags_to_byte(st_cur.f);

endmodule

// File: rtl/xfer_exec_chk.sv
module xfer_exec_chk
    import xfer_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          op_valid,
    input logic [DW-1:0] opcode,
    input logic [DW-1:0] acc,
    input logic [DW-1:0] idx_h,
    input logic [DW-1:0] idx_x,
    input logic [AW-1:0] stk,
    input logic [DW-1:0] ccr,
    input logic          illegal
);

    // R3
    tsx_offset_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && opcode == OPC_TSX) |=> ({idx_h, idx_x} == $past(stk) + 16'd1));

    // R3
    txs_offset_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && opcode == OPC_TXS) |=> (stk == $past({idx_h, idx_x}) - 16'd1 && $stable(ccr)));

    // R2
    move_keeps_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (opcode == OPC_TAX || opcode == OPC_TXA)) |=> $stable(ccr));

    // R5
    test_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (opcode == OPC_TSTA || opcode == OPC_TSTX)) |=>
            ($stable(acc) && $stable(idx_x) && !ccr[CC_V] && $stable(ccr[CC_C])));

    // R6
    sub_keeps_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && opcode == SUB_OPCODES[0]) |=> $stable(ccr[CC_H:CC_I]));

    // R8
    illegal_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |-> ($stable(acc) && $stable(idx_h) && $stable(idx_x) && $stable(stk) && $stable(ccr)));

    // R9
    idle_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> ($stable(acc) && $stable(stk) && $stable(ccr) && !illegal));

    // R10
    fixed_bits_chk: assert property (@(posedge clk) disable iff (rst)
        ccr[6:5] == 2'b11);

endmodule

bind xfer_exec_unit xfer_exec_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .opcode   (opcode),
    .acc      (acc),
    .idx_h    (idx_h),
    .idx_x    (idx_x),
    .stk      (stk),
    .ccr      (ccr),
    .illegal  (illegal)
);

// File: tb/xfer_exec_unit_test.sv
`timescale 1ns/1ps
module xfer_exec_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [7:0]  mem_operand = 8'h00;
    logic [7:0]  acc, idx_h, idx_x, ccr;
    logic [15:0] stk;
    logic        illegal;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    xfer_exec_unit uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .opcode(opcode),
        .mem_operand(mem_operand), .acc(acc), .idx_h(idx_h), .idx_x(idx_x),
        .stk(stk), .ccr(ccr), .illegal(illegal)
    );

    typedef struct {
        logic [7:0]  a, h, x, c;
        logic [15:0] sp;
        logic        ill;
        string       tag;
    } exp_t;

    exp_t sb[$];

    // Reference state built from the requirements
    logic [7:0]  m_a = 8'h00, m_h = 8'h00, m_x = 8'h00, m_c = 8'h68;
    logic [15:0] m_sp = 16'h00FF;

    task automatic check(string tag, bit ok, string got, string want);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %s expected %s", tag, got, want);
        end
    endtask

    function automatic string fmt(logic [7:0] a, logic [7:0] h, logic [7:0] x,
                                  logic [15:0] sp, logic [7:0] c, logic ill);
        return $sformatf("a=%02h h=%02h x=%02h sp=%04h ccr=%02h ill=%0b", a, h, x, sp, c, ill);
    endfunction

    function automatic logic [7:0] tst_ccr(logic [7:0] c, logic [7:0] v);
        logic [7:0] r;
        r    = c;
        r[7] = 1'b0;
        r[2] = v[7];
        r[1] = (v == 8'h00);
        return r;
    endfunction

    // Driver: present one cycle of input, push the expected state after it
    task automatic step(bit vld, logic [7:0] opc, logic [7:0] mem, string tag);
        exp_t       e;
        bit         ill;
        logic [8:0] w;
        @(negedge clk);
        op_valid    = vld;
        opcode      = opc;
        mem_operand = mem;
        ill = 1'b0;
        if (vld) begin
            case (opc)
                8'h97: m_x = m_a;
                8'h9F: m_a = m_x;
                8'h95: {m_h, m_x} = m_sp + 16'd1;
                8'h94: m_sp = {m_h, m_x} - 16'd1;
                8'h84: m_c = m_a | 8'h60;
                8'h85: m_a = m_c;
                8'h4D: m_c = tst_ccr(m_c, m_a);
                8'h5D: m_c = tst_ccr(m_c, m_x);
                8'h3D, 8'h6D, 8'h7D: m_c = tst_ccr(m_c, mem);
                8'hA0, 8'hB0, 8'hC0, 8'hD0, 8'hE0, 8'hF0: begin
                    w = {1'b0, m_a} - {1'b0, mem};
                    m_c = tst_ccr(m_c, w[7:0]);
                    m_c[0] = w[8];
                    m_c[7] = (m_a[7] != mem[7]) && (w[7] != m_a[7]);
                    m_a = w[7:0];
                end
                default: ill = 1'b1;
            endcase
        end
        e.a = m_a; e.h = m_h; e.x = m_x; e.sp = m_sp; e.c = m_c; e.ill = ill; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare after the edge that commits each pushed item
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag,
                      acc == e.a && idx_h == e.h && idx_x == e.x && stk == e.sp &&
                      ccr == e.c && illegal == e.ill,
                      fmt(acc, idx_h, idx_x, stk, ccr, illegal),
                      fmt(e.a, e.h, e.x, e.sp, e.c, e.ill));
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", acc == 8'h00 && idx_h == 8'h00 && idx_x == 8'h00 && stk == 16'h00FF &&
                    ccr == 8'h68 && illegal == 1'b0,
              fmt(acc, idx_h, idx_x, stk, ccr, illegal),
              fmt(8'h00, 8'h00, 8'h00, 16'h00FF, 8'h68, 1'b0));
        @(negedge clk);
        rst = 1'b0;

        step(1, 8'h94, 8'h00, "R3 stack from index 0000 wraps to FFFF");
        step(1, 8'h95, 8'h00, "R3 index from stack FFFF wraps to 0000");
        step(1, 8'hA0, 8'h01, "R6 subtract with borrow");
        step(1, 8'h97, 8'h00, "R2 copy acc to index low");
        step(1, 8'h5D, 8'h00, "R5 test index low negative");
        step(1, 8'hB0, 8'h7F, "R7 subtract form B0");
        step(1, 8'hC0, 8'h01, "R6 signed overflow without borrow");
        step(1, 8'hD0, 8'h7F, "R7 subtract form D0 gives zero");
        step(1, 8'h4D, 8'h00, "R5 test acc zero");
        step(1, 8'h3D, 8'h80, "R5 test memory negative, acc untouched");
        step(1, 8'h6D, 8'h00, "R5 test memory zero");
        step(1, 8'hE0, 8'h80, "R6 overflow together with borrow");
        step(1, 8'h85, 8'h00, "R4 copy ccr to acc");
        step(1, 8'hF0, 8'hED, "R7 subtract form F0");
        step(1, 8'h84, 8'h00, "R10 copy zero into ccr keeps bits 6 and 5");
        step(1, 8'h7D, 8'h01, "R5 test memory positive");
        step(1, 8'h9F, 8'h00, "R2 copy index low to acc");
        step(1, 8'h95, 8'h00, "R3 index from stack plus one");
        step(1, 8'h97, 8'h00, "R2 copy acc to index low again");
        step(1, 8'h94, 8'h00, "R3 stack from index minus one");
        step(1, 8'h84, 8'h00, "R4 copy acc FF into ccr");
        step(1, 8'h00, 8'h00, "R8 unknown opcode 00");
        step(1, 8'h9E, 8'h00, "R8 unknown opcode 9E");
        step(0, 8'h97, 8'h00, "R9 idle cycle with move opcode");
        step(0, 8'hA0, 8'h55, "R9 idle cycle with subtract opcode");
        @(negedge clk);
        op_valid = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule